// File: doc/BRIEF.md
# Commit Thread Selector for a Multithreaded Out-of-Order Core

This block decides, once per cycle, which hardware thread is allowed to retire instructions in a simultaneously multithreaded out-of-order core. For every thread it receives four things: whether the thread is active, whether its reorder buffer holds anything, whether the oldest entry of that buffer is ready to retire, and the sequence number of that oldest entry. It returns a thread index and a valid flag. When no thread qualifies, the index carries a reserved all-ones code.

A static policy input selects the arbitration rule. Round-robin walks a priority list that the block keeps for itself, and each winner is sent to the back of that list. Oldest-ready picks the eligible head with the smallest sequence number, so the instruction that is oldest in program order retires first. A core built with a single thread skips arbitration and selects that thread whenever it is active.

Top module: `commit_sel`

## Requirements
- R1: The policy input is decoded as follows: 2'b00 is round-robin, 2'b01 is oldest-ready, 2'b10 (greedy) behaves exactly as oldest-ready, and 2'b11 behaves exactly as round-robin, including the list update.
- R2: With more than one thread, a thread is eligible only when its active, head-valid and head-ready inputs are all 1, and only an eligible thread is ever selected.
- R3: Under round-robin, the selected thread is the first eligible entry when the priority list is read from the front. After reset the list holds thread 0 at the front, then 1, 2 and so on in ascending order.
- R4: Under round-robin, on the clock edge after a valid selection, the selected thread moves to the back of the priority list and every other entry keeps its relative order.
- R5: Under oldest-ready, the selected thread is the eligible thread whose head sequence number (unsigned, SEQ_W bits, thread t in bits [t*SEQ_W +: SEQ_W]) is the smallest.
- R6: Under oldest-ready, when eligible heads have equal sequence numbers, the lower thread index wins.
- R7: With more than one thread, selValid is 1 exactly when some thread is eligible. When it is 0, selId is all ones. selId is $clog2(NUM_THREADS+1) bits wide, so the all-ones code is never a real thread index.
- R8: With NUM_THREADS = 1, selValid equals the active input of thread 0, head-valid and head-ready are ignored, and selId is 0 when valid and all ones (1'b1) otherwise.
- R9: Selections made under oldest-ready leave the priority list unchanged.
- R10: The selection is combinational. It reflects the inputs of the same cycle, and only the priority list is registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the priority list |
| policy | input | 2 | Arbitration policy code (R1) |
| thrActive | input | NUM_THREADS | Per-thread active flag |
| headValid | input | NUM_THREADS | Per-thread reorder buffer not empty |
| headReady | input | NUM_THREADS | Per-thread head entry ready to retire |
| headSeq | input | NUM_THREADS*SEQ_W | Per-thread head sequence numbers, packed by thread index |
| selValid | output | 1 | A thread is selected this cycle |
| selId | output | $clog2(NUM_THREADS+1) | Selected thread index, or all ones when none |

## Verification
The assertions assume that the policy input does not change while round-robin selections are in progress, unless the change is deliberate. They also assume that sequence numbers are compared as plain unsigned values with no wraparound, so the age check is a direct comparison across eligible heads. The directed stimulus keeps every sequence number well inside the field. It changes inputs only at falling edges, so every policy switch is seen as a whole cycle by both the list update and the checker's record of the previous winner. Equal sequence numbers are used on purpose, to exercise the index tie-break.

// File: rtl/commit_sel_pkg.sv
package commit_sel_pkg;

  typedef enum logic [1:0] {
    POL_ROUND  = 2'b00,
    POL_AGE    = 2'b01,
    POL_GREEDY = 2'b10,
    POL_SPARE  = 2'b11
  } policy_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic useAge;    // select from the age comparator
    logic rotateEn;  // move the round-robin winner to the back
  } sel_strobe_t;

endpackage

// File: rtl/commit_sel_ctrl.sv
module commit_sel_ctrl
  import commit_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic [1:0]  policy,
  input  logic        rrHit,
  output sel_strobe_t strobes
);

  policy_e polDec;

  always_comb begin
    polDec = policy_e'(policy);
    strobes = '0;
    unique case (polDec)
      POL_AGE, POL_GREEDY: strobes.useAge = 1'b1;   // R1 greedy acts as oldest-ready
      POL_ROUND, POL_SPARE: strobes.useAge = 1'b0;  // R1 spare acts as round-robin
      default:              strobes.useAge = 1'b0;
    endcase
    // R4 / R9: the list moves only for a round-robin winner
    strobes.rotateEn = (NUM_THREADS > 1) && !strobes.useAge && rrHit;
  end

endmodule

// File: rtl/commit_sel_dpath.sv
module commit_sel_dpath
  import commit_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  parameter int ID_W        = $clog2(NUM_THREADS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  sel_strobe_t                  strobes,
  input  logic [NUM_THREADS-1:0]       thrActive,
  input  logic [NUM_THREADS-1:0]       headValid,
  input  logic [NUM_THREADS-1:0]       headReady,
  input  logic [NUM_THREADS*SEQ_W-1:0] headSeq,
  output logic                         rrHit,
  output logic                         selValid,
  output logic [ID_W-1:0]              selId
);

  localparam logic [ID_W-1:0] NO_THREAD = '1;

  generate
    if (NUM_THREADS == 1) begin : g_single
      // R8: no arbitration
      assign rrHit    = 1'b0;
      assign selValid = thrActive[0];
      assign selId    = thrActive[0] ? '0 : NO_THREAD;
    end else begin : g_multi
      logic [NUM_THREADS-1:0] elig;
      logic [ID_W-1:0] order     [NUM_THREADS];
      logic [ID_W-1:0] nextOrder [NUM_THREADS];
      logic [ID_W-1:0] rrId;
      logic [ID_W-1:0] rrPos;
      logic            ageHit;
      logic [ID_W-1:0] ageId;
      logic [SEQ_W-1:0] ageSeq;

      assign elig = thrActive & headValid & headReady;  // R2

      // Round-robin walk from the list front (R3)
      always_comb begin
        rrHit = 1'b0;
        rrId  = NO_THREAD;
        rrPos = '0;
        for (int i = 0; i < NUM_THREADS; i++) begin
          for (int t = 0; t < NUM_THREADS; t++) begin
            if (!rrHit && order[i] == ID_W'(t) && elig[t]) begin
              rrHit = 1'b1;
              rrId  = ID_W'(t);
              rrPos = ID_W'(i);
            end
          end
        end
      end

      // Oldest-ready scan: strict less-than keeps the lower index on ties (R5, R6)
      always_comb begin
        ageHit = 1'b0;
        ageId  = NO_THREAD;
        ageSeq = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
          if (elig[t] && (!ageHit || headSeq[t*SEQ_W +: SEQ_W] < ageSeq)) begin
            ageHit = 1'b1;
            ageId  = ID_W'(t);
            ageSeq = headSeq[t*SEQ_W +: SEQ_W];
          end
        end
      end

      // Output mux (R7, R10)
      always_comb begin
        if (strobes.useAge) begin
          selValid = ageHit;
          selId    = ageHit ? ageId : NO_THREAD;
        end else begin
          selValid = rrHit;
          selId    = rrHit ? rrId : NO_THREAD;
        end
      end

      // Winner to the back, entries behind it close the gap (R4)
      always_comb begin
        for (int i = 0; i < NUM_THREADS - 1; i++) begin
          nextOrder[i] = (ID_W'(i) < rrPos) ? order[i] : order[i+1];
        end
        nextOrder[NUM_THREADS-1] = rrId;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < NUM_THREADS; i++) order[i] <= ID_W'(i);
        end else if (strobes.rotateEn) begin
          for (int i = 0; i < NUM_THREADS; i++) order[i] <= nextOrder[i];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/commit_sel.sv
module commit_sel
  import commit_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int ID_W       = $clog2(NUM_THREADS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   policy,
  input  logic [NUM_THREADS-1:0]       thrActive,
  input  logic [NUM_THREADS-1:0]       headValid,
  input  logic [NUM_THREADS-1:0]       headReady,
  input  logic [NUM_THREADS*SEQ_W-1:0] headSeq,
  output logic                         selValid,
  output logic [ID_W-1:0]              selId
);

  sel_strobe_t strobes;
  logic        rrHit;

  commit_sel_ctrl #(.NUM_THREADS(NUM_THREADS)) u_ctrl (
    .policy  (policy),
    .rrHit   (rrHit),
    .strobes (strobes)
  );

  commit_sel_dpath #(
    .NUM_THREADS (NUM_THREADS),
    .SEQ_W       (SEQ_W),
    .ID_W        (ID_W)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .thrActive (thrActive),
    .headValid (headValid),
    .headReady (headReady),
    .headSeq   (headSeq),
    .rrHit     (rrHit),
    .selValid  (selValid),
    .selId     (selId)
  );

endmodule

// File: rtl/commit_sel_chk.sv
module commit_sel_chk #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  parameter int ID_W        = $clog2(NUM_THREADS + 1)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [1:0]                   policy,
  input logic [NUM_THREADS-1:0]       thrActive,
  input logic [NUM_THREADS-1:0]       headValid,
  input logic [NUM_THREADS-1:0]       headReady,
  input logic [NUM_THREADS*SEQ_W-1:0] headSeq,
  input logic                         selValid,
  input logic [ID_W-1:0]              selId
);

  generate
    if (NUM_THREADS == 1) begin : g_single
      p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        selValid == thrActive[0])
        else $error("single thread valid mismatch");
    end else begin : g_multi
      logic [NUM_THREADS-1:0] elig;
      logic                   selElig;
      logic [SEQ_W-1:0]       selSeq;
      logic                   olderSeen;
      logic                   otherElig;
      logic                   ageNow;
      logic                   rrNow;
      logic                   prevRr;
      logic [ID_W-1:0]        prevId;

      assign elig   = thrActive & headValid & headReady;
      assign ageNow = (policy == 2'b01) || (policy == 2'b10);
      assign rrNow  = !ageNow;

      always_comb begin
        selElig = 1'b0;
        selSeq  = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
          if (selId == ID_W'(t)) begin
            selElig = elig[t];
            selSeq  = headSeq[t*SEQ_W +: SEQ_W];
          end
        end
      end

      always_comb begin
        olderSeen = 1'b0;
        otherElig = 1'b0;
        for (int t = 0; t < NUM_THREADS; t++) begin
          if (elig[t] && (headSeq[t*SEQ_W +: SEQ_W] < selSeq ||
              (headSeq[t*SEQ_W +: SEQ_W] == selSeq && ID_W'(t) < selId)))
            olderSeen = 1'b1;
          if (elig[t] && ID_W'(t) != prevId) otherElig = 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prevRr <= 1'b0;
          prevId <= '0;
        end else begin
          prevRr <= rrNow && selValid;
          prevId <= selId;
        end
      end

      p_elig_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        selValid |-> selElig)
        else $error("selected thread not eligible");

      p_valid_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
        selValid == (elig != '0))
        else $error("valid flag disagrees with eligibility");

      p_invalid_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !selValid |-> (selId == '1))
        else $error("invalid selection without all-ones code");

      // R5 and R6: no eligible head is older, or equal with a lower index
      p_age_oldest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ageNow && selValid) |-> !olderSeen)
        else $error("oldest-ready picked a younger head");

      p_rr_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prevRr && rrNow && otherElig) |-> (selId != prevId))
        else $error("round-robin winner not moved back");
    end
  endgenerate

endmodule

bind commit_sel commit_sel_chk #(
  .NUM_THREADS (NUM_THREADS),
  .SEQ_W       (SEQ_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .policy    (policy),
  .thrActive (thrActive),
  .headValid (headValid),
  .headReady (headReady),
  .headSeq   (headSeq),
  .selValid  (selValid),
  .selId     (selId)
);

// File: tb/commit_sel_tb.sv
`timescale 1ns/1ps
module commit_sel_tb;

  localparam int N  = 4;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    policy = 2'b00;
  logic [N-1:0]  thrActive = '0;
  logic [N-1:0]  headValid = '0;
  logic [N-1:0]  headReady = '0;
  logic [N*SW-1:0] headSeq = '0;
  logic          selValid;
  logic [2:0]    selId;

  logic          sAct = 1'b0;
  logic          sVal = 1'b0;
  logic          sRdy = 1'b0;
  logic          sSelValid;
  logic [0:0]    sSelId;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  commit_sel #(.NUM_THREADS(N), .SEQ_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .policy(policy),
    .thrActive(thrActive), .headValid(headValid), .headReady(headReady),
    .headSeq(headSeq), .selValid(selValid), .selId(selId)
  );

  commit_sel #(.NUM_THREADS(1), .SEQ_W(SW)) u_single (
    .clk(clk), .rst_n(rst_n), .policy(policy),
    .thrActive(sAct), .headValid(sVal), .headReady(sRdy),
    .headSeq(16'h0007), .selValid(sSelValid), .selId(sSelId)
  );

  task automatic check(input string req, input logic expV, input logic [2:0] expId);
    checks++;
    if (selValid !== expV || selId !== expId) begin
      fails++;
      $display("FAIL %s: actual valid=%0b id=%0d expected valid=%0b id=%0d",
               req, selValid, selId, expV, expId);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; policy = 2'b00;
    thrActive = '0; headValid = '0; headReady = '0; headSeq = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic allElig();
    thrActive = '1; headValid = '1; headReady = '1;
  endtask

  // Inputs change at a falling edge; sample 2 ns later (combinational output)
  task automatic settle();
    #2;
  endtask

  task automatic nextCycle();
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    settle(); check("R7 reset no eligible", 1'b0, 3'd7);
    policy = 2'b01;
    settle(); check("R7 none eligible oldest", 1'b0, 3'd7);
  endtask

  task automatic testRrCycle();
    doReset();
    allElig(); headSeq = {16'd1, 16'd2, 16'd3, 16'd4};
    for (int k = 0; k < 5; k++) begin
      settle(); check("R3 R4 round-robin cycle", 1'b1, 3'(k % 4));
      nextCycle();
    end
  endtask

  task automatic testElig();
    doReset();
    thrActive = 4'b1101; headValid = 4'b1011; headReady = 4'b1110;
    settle(); check("R2 R10 eligibility round-robin", 1'b1, 3'd3);
    policy = 2'b01;
    settle(); check("R2 eligibility oldest", 1'b1, 3'd3);
  endtask

  task automatic testRrSubset();
    doReset();
    thrActive = 4'b0110; headValid = 4'b0110; headReady = 4'b0110;
    settle(); check("R3 first eligible", 1'b1, 3'd1);
    nextCycle();
    settle(); check("R4 after move", 1'b1, 3'd2);
    nextCycle(); allElig();
    settle(); check("R4 relative order kept", 1'b1, 3'd0);
    nextCycle();
    settle(); check("R4 list order", 1'b1, 3'd3);
  endtask

  task automatic testAge();
    doReset();
    policy = 2'b01; allElig();
    headSeq = {16'd20, 16'd30, 16'd20, 16'd50};
    settle(); check("R6 tie lower index", 1'b1, 3'd1);
    headReady = 4'b1101;
    settle(); check("R5 oldest ready", 1'b1, 3'd3);
    headReady = '1; policy = 2'b10;
    settle(); check("R1 greedy as oldest", 1'b1, 3'd1);
    headSeq = {16'd70, 16'd80, 16'd90, 16'd100};
    settle(); check("R5 descending ages", 1'b1, 3'd3);
  endtask

  task automatic testNoRotate();
    doReset();
    policy = 2'b01; allElig();
    headSeq = {16'd9, 16'd9, 16'd9, 16'd5};
    for (int k = 0; k < 3; k++) begin
      settle(); check("R5 oldest held", 1'b1, 3'd0);
      nextCycle();
    end
    policy = 2'b00;
    settle(); check("R9 list untouched", 1'b1, 3'd0);
    nextCycle(); policy = 2'b11;
    settle(); check("R1 spare as round-robin", 1'b1, 3'd1);
    nextCycle(); policy = 2'b00;
    settle(); check("R1 spare moved list", 1'b1, 3'd2);
  endtask

  task automatic testNone();
    doReset();
    policy = 2'b01; thrActive = '1; headValid = '1; headReady = '0;
    settle(); check("R7 none ready", 1'b0, 3'd7);
  endtask

  task automatic testSingle();
    doReset();
    sAct = 1'b0; sVal = 1'b1; sRdy = 1'b1;
    settle(); checks++;
    if (sSelValid !== 1'b0 || sSelId !== 1'b1) begin
      fails++;
      $display("FAIL R8 inactive: actual valid=%0b id=%0d expected valid=0 id=1",
               sSelValid, sSelId);
    end
    sAct = 1'b1; sVal = 1'b0; sRdy = 1'b0;
    settle(); checks++;
    if (sSelValid !== 1'b1 || sSelId !== 1'b0) begin
      fails++;
      $display("FAIL R8 active no arbitration: actual valid=%0b id=%0d expected valid=1 id=0",
               sSelValid, sSelId);
    end
  endtask

  initial begin
    testReset();
    testRrCycle();
    testElig();
    testRrSubset();
    testAge();
    testNoRotate();
    testNone();
    testSingle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule